// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block controls a bank of bidirectional pins. Software writes an output value latch, a per-pin direction mask and a per-pin low-strength drive mask through a small register interface. The block turns these into output-enable, output-value and drive-select signals for the pads. Pad levels come back through a two-stage synchronizer, so software can read the pins safely. Each pin is an input after reset, with full-strength drive.

Two serial peripherals can take over pins without touching the stored direction bits. The first is an asynchronous transmitter/receiver that owns one transmit pin and one receive pin. The second is a routed SPI that owns a parameterized set of pins and sets the direction and value of each one. When a peripheral is switched off, its pins follow the stored direction bits again. If both peripherals claim the same pin, the asynchronous serial peripheral wins.

Register offsets: 0 is the port value, 1 is the synchronized pad input (read-only), 2 is the direction mask, 3 is the drive-strength mask.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output latch, the direction mask and the drive mask all read 0. Every `pad_oe` bit is 0 and every `pad_rdr` bit is 0.
- R2: With no peripheral enabled, direction bit 1 makes the pin an output (`pad_oe`=1) that drives the latched data bit. Direction bit 0 makes it an input.
- R3: While `ser_en`=1, pin 1 is an output driving `ser_txd` and pin 0 is an input, whatever the direction mask holds. The direction mask read back at offset 2 keeps its written value.
- R4: While `spi_en`=1 (and the serial peripheral is off), each pin in the SPI set (pins 0 to 3 by default) takes its direction from `spi_dir` (1 = output) and its value from `spi_do`. Pins outside the set follow the direction mask. The mask itself stays unchanged.
- R5: When the overriding peripheral is disabled, `pad_oe` again equals the stored direction mask.
- R6: When both peripherals are enabled, pins 0 and 1 follow the serial peripheral's rule (pin 0 input, pin 1 driving `ser_txd`), not the SPI request.
- R7: `pad_rdr` bit i equals drive-mask bit i (1 = reduced drive) while pin i is an output, and is 0 while pin i is an input. This holds whichever function owns the pin.
- R8: A change on `pad_di` shows up at offset 1 after exactly two rising clock edges. After one edge the old value is still read.
- R9: A read at offset 0 returns the driven value for pins that are currently outputs, and the synchronized pad value for pins that are currently inputs.
- R10: A write to offset 1 changes no register. The outputs and the values read at offsets 0, 2 and 3 stay the same.
- R11: Offsets 0, 2 and 3 accept writes at any time, and a read returns the value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ser_en | input | 1 | Asynchronous serial peripheral enable |
| ser_txd | input | 1 | Serial transmit data |
| spi_en | input | 1 | Routed SPI enable |
| spi_dir | input | 8 | SPI per-pin direction request, 1 = output |
| spi_do | input | 8 | SPI per-pin output value |
| pad_di | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output value |
| pad_rdr | output | 8 | Per-pin reduced-drive select |

## Verification
Assertions check the following on every cycle:
- the serial peripheral's fixed pin roles;
- SPI ownership of its pin set;
- return to the stored mask when both peripherals are off;
- the gating of the drive select by direction;
- the two-edge synchronizer latency;
- that a write to the input offset leaves all registers untouched.

Only the bench's scenarios can show certain things. These are that the stored direction mask survives an override and reads back intact, the priority outcome on the shared pins, and the mixed output/input composition of a port read. The bench also shows that the old pad value is still visible after one edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 2'd0,
        REG_INPUT = 2'd1,
        REG_DIR   = 2'd2,
        REG_DRIVE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic dout;
    } pin_drv_t;

    // Resolve one pin: serial peripheral beats SPI, SPI beats the stored mask.
    function automatic pin_drv_t resolve_pin(
        input logic ser_en,
        input logic is_tx,
        input logic is_rx,
        input logic ser_txd,
        input logic spi_en,
        input logic spi_own,
        input logic spi_dir,
        input logic spi_do,
        input logic dir_bit,
        input logic data_bit
    );
        pin_drv_t r;
        r.oe   = dir_bit;
        r.dout = data_bit;
        if (spi_en && spi_own) begin
            r.oe   = spi_dir;
            r.dout = spi_do;
        end
        if (ser_en && is_tx) begin
            r.oe   = 1'b1;
            r.dout = ser_txd;
        end else if (ser_en && is_rx) begin
            r.oe   = 1'b0;
            r.dout = data_bit;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_di,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= pad_di;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    // Warm-up counter so the latency check only looks at post-reset history.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst)                warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            p_sync_latency_r8: assert property (@(posedge clk) disable iff (rst)
                (warm_q == 2'd2) |-> (sync_out == $past(pad_di, 2)));
        end
    endgenerate
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pkg::*;
#(
    parameter int         W          = 8,
    parameter int         SER_TX_PIN = 1,
    parameter int         SER_RX_PIN = 0,
    parameter logic [W-1:0] SPI_MASK = 8'h0F
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_en,
    input  logic         ser_txd,
    input  logic         spi_en,
    input  logic [W-1:0] spi_dir,
    input  logic [W-1:0] spi_do,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    output logic [W-1:0] eff_oe,
    output logic [W-1:0] eff_do
);
    pin_drv_t drv [W];

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            localparam logic IS_TX = (i == SER_TX_PIN);
            localparam logic IS_RX = (i == SER_RX_PIN);
            localparam logic OWN   = SPI_MASK[i];
            assign drv[i] = resolve_pin(ser_en, IS_TX, IS_RX, ser_txd,
                                        spi_en, OWN, spi_dir[i], spi_do[i],
                                        dir_q[i], data_q[i]);
            assign eff_oe[i] = drv[i].oe;
            assign eff_do[i] = drv[i].dout;
        end
    endgenerate

    p_ser_rx_input_r3: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> !eff_oe[SER_RX_PIN]);
    p_ser_tx_drive_r6: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> (eff_oe[SER_TX_PIN] && (eff_do[SER_TX_PIN] == ser_txd)));
    p_spi_owns_r4: assert property (@(posedge clk) disable iff (rst)
        (spi_en && !ser_en) |-> (((eff_oe ^ spi_dir) & SPI_MASK) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      eff_oe,
    input  logic [W-1:0]      eff_do,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      data_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      rdr_q,
    output logic [W-1:0]      rdata
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            rdr_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_DATA:  data_q <= wdata;
                REG_DIR:   dir_q  <= wdata;
                REG_DRIVE: rdr_q  <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_DATA:  rdata = (eff_oe & eff_do) | (~eff_oe & pin_sync);
            REG_INPUT: rdata = pin_sync;
            REG_DIR:   rdata = dir_q;
            default:   rdata = rdr_q;
        endcase
    end

    p_ro_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_INPUT) |=>
            ($stable(data_q) && $stable(dir_q) && $stable(rdr_q)));
    p_dir_write_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_DIR) |=> (dir_q == $past(wdata)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int           W          = 8,
    parameter int           SER_TX_PIN = 1,
    parameter int           SER_RX_PIN = 0,
    parameter logic [W-1:0] SPI_MASK   = 8'h0F,
    parameter int           SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata,
    input  logic              ser_en,
    input  logic              ser_txd,
    input  logic              spi_en,
    input  logic [W-1:0]      spi_dir,
    input  logic [W-1:0]      spi_do,
    input  logic [W-1:0]      pad_di,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_do,
    output logic [W-1:0]      pad_rdr
);
    logic [W-1:0] data_q, dir_q, rdr_q, pin_sync, eff_oe, eff_do;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pad_di(pad_di), .sync_out(pin_sync)
    );

    gpio_pin_mux #(.W(W), .SER_TX_PIN(SER_TX_PIN), .SER_RX_PIN(SER_RX_PIN),
                   .SPI_MASK(SPI_MASK)) u_mux (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_txd(ser_txd),
        .spi_en(spi_en), .spi_dir(spi_dir), .spi_do(spi_do),
        .dir_q(dir_q), .data_q(data_q), .eff_oe(eff_oe), .eff_do(eff_do)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .eff_oe(eff_oe), .eff_do(eff_do), .pin_sync(pin_sync),
        .data_q(data_q), .dir_q(dir_q), .rdr_q(rdr_q), .rdata(rdata)
    );

    assign pad_oe  = eff_oe;
    assign pad_do  = eff_do;
    assign pad_rdr = rdr_q & eff_oe;

    p_rdr_input_off_r7: assert property (@(posedge clk) disable iff (rst)
        (pad_rdr & ~pad_oe) == '0);
    p_release_follows_mask_r5: assert property (@(posedge clk) disable iff (rst)
        (!ser_en && !spi_en) |-> (pad_oe == dir_q));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ser_en = 1'b0, ser_txd = 1'b0, spi_en = 1'b0;
    logic [7:0] spi_dir = 8'h00, spi_do = 8'h00, pad_di = 8'h00;
    logic [7:0] pad_oe, pad_do, pad_rdr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ser_en(ser_en), .ser_txd(ser_txd), .spi_en(spi_en),
        .spi_dir(spi_dir), .spi_do(spi_do), .pad_di(pad_di),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_rdr(pad_rdr)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1", "pad_oe", pad_oe, 8'h00);
        check("R1", "pad_rdr", pad_rdr, 8'h00);
        rd(2'd0, v); check("R1", "data", v, 8'h00);
        rd(2'd2, v); check("R1", "dir", v, 8'h00);
        rd(2'd3, v); check("R1", "drive", v, 8'h00);
    endtask

    task automatic t_dir_output();
        wr(2'd0, 8'hA5);
        wr(2'd2, 8'hF0);
        check("R2", "pad_oe", pad_oe, 8'hF0);
        check("R2", "pad_do outs", pad_do & 8'hF0, 8'hA0);
    endtask

    task automatic t_serial();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        @(negedge clk); ser_en = 1'b1; ser_txd = 1'b1; #1;
        check("R3", "pad_oe", pad_oe, 8'h02);
        check("R3", "txd", {7'd0, pad_do[1]}, 8'h01);
        rd(2'd2, v); check("R3", "dir kept", v, 8'h01);
        @(negedge clk); ser_en = 1'b0; #1;
        check("R5", "released oe", pad_oe, 8'h01);
    endtask

    task automatic t_spi();
        logic [7:0] v;
        wr(2'd2, 8'h00);
        @(negedge clk); spi_en = 1'b1; spi_dir = 8'hFA; spi_do = 8'h08; #1;
        check("R4", "pad_oe", pad_oe, 8'h0A);
        check("R4", "pad_do owned", pad_do & 8'h0A, 8'h08);
        rd(2'd2, v); check("R4", "dir kept", v, 8'h00);
    endtask

    task automatic t_priority();
        @(negedge clk); spi_dir = 8'h01; spi_do = 8'h01; ser_en = 1'b1; ser_txd = 1'b0; #1;
        check("R6", "pad_oe", pad_oe, 8'h02);
        check("R6", "txd low", pad_do & 8'h02, 8'h00);
        @(negedge clk); ser_txd = 1'b1; #1;
        check("R6", "txd high", pad_do & 8'h02, 8'h02);
        @(negedge clk); ser_en = 1'b0; spi_en = 1'b0; ser_txd = 1'b0; #1;
        check("R5", "both off", pad_oe, 8'h00);
    endtask

    task automatic t_rdr();
        wr(2'd3, 8'hFF);
        wr(2'd2, 8'h0F);
        check("R7", "rdr outs", pad_rdr, 8'h0F);
        @(negedge clk); ser_en = 1'b1; #1;
        check("R7", "rdr serial", pad_rdr, 8'h0E);
        @(negedge clk); ser_en = 1'b0;
        wr(2'd2, 8'h00);
        check("R7", "rdr inputs", pad_rdr, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        @(negedge clk); pad_di = 8'h00;
        repeat (3) @(negedge clk);
        pad_di = 8'h5A;
        @(negedge clk);
        rd(2'd1, v); check("R8", "after 1 edge", v, 8'h00);
        @(negedge clk);
        rd(2'd1, v); check("R8", "after 2 edges", v, 8'h5A);
    endtask

    task automatic t_port_read();
        logic [7:0] v;
        wr(2'd0, 8'hC3);
        wr(2'd2, 8'hF0);
        rd(2'd0, v); check("R9", "mixed read", v, 8'hCA);
    endtask

    task automatic t_ro_write();
        logic [7:0] v;
        wr(2'd1, 8'hFF);
        rd(2'd0, v); check("R10", "data", v, 8'hCA);
        rd(2'd2, v); check("R10", "dir", v, 8'hF0);
        rd(2'd3, v); check("R10", "drive", v, 8'hFF);
        check("R10", "pad_oe", pad_oe, 8'hF0);
    endtask

    task automatic t_rw();
        logic [7:0] v;
        wr(2'd2, 8'h96);
        wr(2'd3, 8'h69);
        rd(2'd2, v); check("R11", "dir", v, 8'h96);
        rd(2'd3, v); check("R11", "drive", v, 8'h69);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h3C);
        rd(2'd0, v); check("R11", "data", v, 8'h3C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_dir_output();
        t_serial();
        t_spi();
        t_priority();
        t_rdr();
        t_sync();
        t_port_read();
        t_ro_write();
        t_rw();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule